// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block lets one device on an SMBus-style two-wire bus signal a fault and then identify itself to the host. When the local fault input is seen, the block asserts its alert output. The alert output is an active-low, open-drain line, so the port reports "pull the line low" and several devices can share one wire. The host reacts by issuing a read to the shared alert response address. Every device that is still waiting to be identified acknowledges that read. Each one then puts its own 7-bit address on SDA, one bit at a time, as the data byte.

SDA is a wired-AND line, and each responder checks every bit it leaves high against the level it samples. A device that sees a 0 where it released a 1 has lost arbitration. It goes quiet for the rest of that transfer. The device with the lowest address therefore finishes the byte and counts as identified.

An identified device ignores further alert response reads. Its alert stays asserted until the host signals a status read while the fault input is low. The block samples SCL and SDA from an already synchronised bit-level bus front end, which it shares with the register protocol engine. It only ever pulls SDA low.

Top module: `alert_ara_responder`

## Requirements
- R1: After reset `alert_pull` is 0. When `fault` is 1 in a cycle while no alert is active, `alert_pull` becomes 1 at the next clock edge.
- R2: The block acknowledges only the address byte 0x19, which is address 0001100 followed by a read bit of 1. The acknowledge is SDA held low through the ninth SCL pulse. A read of the block's own address, or a write to 0001100, gets no acknowledge.
- R3: The block acknowledges the alert response read only while its alert is active and it has not yet been identified. Otherwise `sda_pull` stays 0 for the whole transfer.
- R4: After its acknowledge, the block sends the byte {OWN_ADDR, 0}, MSB first. Each bit is set up after an SCL falling edge (`sda_pull` = 1 for a 0 bit) and held unchanged across the SCL rising edge. SDA is released again after the eighth data bit.
- R5: At an SCL rising edge, if the block released a 1 but samples SDA at 0, it stops driving for the rest of the transfer and keeps its alert asserted. Among several alerting devices, the lowest address wins.
- R6: A block that sends all eight data bits without losing arbitration becomes identified. It answers no further alert response read until its alert has been cleared and raised again.
- R7: An identified block releases its alert at the clock edge where `status_read` is 1 and `fault` is 0.
- R8: A `status_read` while `fault` is still 1, or while the block is not yet identified, leaves `alert_pull` at 1. The fault going away without a status read also leaves `alert_pull` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronised level of the bus clock line |
| sda_in | input | 1 | Synchronised level of the bus data line |
| fault | input | 1 | Local fault condition present |
| status_read | input | 1 | One-cycle pulse: host has read the status registers |
| sda_pull | output | 1 | 1 pulls SDA low (open drain) |
| alert_pull | output | 1 | 1 pulls the shared active-low alert line low |

## Verification
The bench builds two instances on a shared wired-AND SDA line. One uses OWN_ADDR 7'h2C and the other uses 7'h29. The two addresses match in their upper four bits, so both devices send several matching 1s and 0s before the 7'h2C device loses at address bit 2. This shows that arbitration loss happens mid-byte and not only at the first bit. It also covers the follow-up read in which the loser is finally identified. A behavioural alert model for both devices is compared on every clock. This makes the ordering of clears, status reads with a fault still present, and re-raised alerts visible at the ports.

// File: rtl/alert_resp_pkg.sv
package alert_resp_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100;

    typedef enum logic [1:0] {
        AL_IDLE,
        AL_PEND,
        AL_IDENT
    } alert_st_e;

    typedef enum logic [2:0] {
        XF_IDLE,
        XF_ADDR,
        XF_ACK_SET,
        XF_ACK_HOLD,
        XF_DATA,
        XF_TAIL,
        XF_WAIT
    } xfer_st_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [BYTE_W-1:0] ara_read_byte();
        return {ARA_ADDR, 1'b1};
    endfunction

    function automatic logic [BYTE_W-1:0] reply_byte(input logic [ADDR_W-1:0] a);
        return {a, 1'b0};
    endfunction

endpackage

// File: rtl/ara_bus_edge.sv
module ara_bus_edge
    import alert_resp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    always_comb begin
        ev.scl_rise = scl_in & ~scl_q;
        ev.scl_fall = ~scl_in & scl_q;
        ev.start    = scl_in & scl_q & sda_q & ~sda_in;
        ev.stop     = scl_in & scl_q & ~sda_q & sda_in;
    end

endmodule

// File: rtl/ara_alert_state.sv
module ara_alert_state
    import alert_resp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fault,
    input  logic status_read,
    input  logic won,
    output logic alert_pull,
    output logic pending
);

    alert_st_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= AL_IDLE;
        end else begin
            case (st)
                AL_IDLE:  if (fault) st <= AL_PEND;
                AL_PEND:  if (won) st <= AL_IDENT;
                AL_IDENT: if (status_read && !fault) st <= AL_IDLE;
                default:  st <= AL_IDLE;
            endcase
        end
    end

    assign alert_pull = (st != AL_IDLE);
    assign pending    = (st == AL_PEND);

    AST_RISE_NEEDS_FAULT: assert property (@(posedge clk) disable iff (rst)
        $rose(alert_pull) |-> $past(fault)); // R1

    AST_FALL_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(alert_pull) |-> $past(status_read && !fault && st == AL_IDENT)); // R7

    AST_FAULT_HOLDS_ALERT: assert property (@(posedge clk) disable iff (rst)
        (alert_pull && fault) |=> alert_pull); // R8

    AST_WIN_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
        won |-> pending); // R6

endmodule

// File: rtl/ara_xfer.sv
module ara_xfer
    import alert_resp_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h2C
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  logic    sda_in,
    input  logic    pending,
    output logic    sda_pull,
    output logic    won
);

    localparam logic [BYTE_W-1:0] REPLY = reply_byte(OWN_ADDR);

    xfer_st_e          st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_next;
    logic              lost;

    assign rx_next = {rx_sh[BYTE_W-2:0], sda_in};
    assign lost    = (st == XF_DATA) && ev.scl_rise && tx_sh[BYTE_W-1] && !sda_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= XF_IDLE;
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            sda_pull <= 1'b0;
            won      <= 1'b0;
        end else begin
            won <= 1'b0;
            if (ev.start) begin
                st       <= XF_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                st       <= XF_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (st)
                    XF_ADDR: begin
                        if (ev.scl_rise) begin
                            rx_sh <= rx_next;
                            cnt   <= cnt + CNT_W'(1);
                            if (cnt == CNT_LAST) begin
                                st <= (rx_next == ara_read_byte() && pending)
                                      ? XF_ACK_SET : XF_WAIT;
                            end
                        end
                    end
                    XF_ACK_SET: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b1;
                            st       <= XF_ACK_HOLD;
                        end
                    end
                    XF_ACK_HOLD: begin
                        if (ev.scl_fall) begin
                            tx_sh    <= REPLY;
                            sda_pull <= ~REPLY[BYTE_W-1];
                            cnt      <= '0;
                            st       <= XF_DATA;
                        end
                    end
                    XF_DATA: begin
                        if (lost) begin
                            sda_pull <= 1'b0;
                            st       <= XF_WAIT;
                        end else if (ev.scl_rise) begin
                            if (cnt == CNT_LAST) begin
                                won <= 1'b1;
                                st  <= XF_TAIL;
                            end else begin
                                cnt   <= cnt + CNT_W'(1);
                                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                            end
                        end else if (ev.scl_fall) begin
                            sda_pull <= ~tx_sh[BYTE_W-1];
                        end
                    end
                    XF_TAIL: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b0;
                            st       <= XF_WAIT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ACK_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (st == XF_ACK_SET || st == XF_ACK_HOLD) |-> pending); // R3

    AST_LOSS_RELEASES: assert property (@(posedge clk) disable iff (rst)
        lost |=> (!sda_pull && st == XF_WAIT)); // R5

    AST_DATA_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (ev.scl_rise && st == XF_DATA) |=> $stable(sda_pull)); // R4

    AST_ACK_ONLY_ARA: assert property (@(posedge clk) disable iff (rst)
        (st == XF_ADDR && ev.scl_rise && cnt == CNT_LAST && rx_next != ara_read_byte())
        |=> st == XF_WAIT); // R2

endmodule

// File: rtl/alert_ara_responder.sv
module alert_ara_responder
    import alert_resp_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h2C
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic fault,
    input  logic status_read,
    output logic sda_pull,
    output logic alert_pull
);

    if (OWN_ADDR == ARA_ADDR) begin : g_bad_addr
        $error("OWN_ADDR must differ from the alert response address");
    end

    bus_ev_t ev;
    logic    pending;
    logic    won;

    ara_bus_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    ara_xfer #(.OWN_ADDR(OWN_ADDR)) u_xfer (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .sda_in   (sda_in),
        .pending  (pending),
        .sda_pull (sda_pull),
        .won      (won)
    );

    ara_alert_state u_alert (
        .clk         (clk),
        .rst         (rst),
        .fault       (fault),
        .status_read (status_read),
        .won         (won),
        .alert_pull  (alert_pull),
        .pending     (pending)
    );

endmodule

// File: tb/alert_ara_responder_test.sv
module alert_ara_responder_test;

    localparam logic [6:0] A_UUT  = 7'h2C;
    localparam logic [6:0] A_PEER = 7'h29;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_pull = 1'b0;
    logic fault_u = 1'b0, fault_p = 1'b0;
    logic rd_u = 1'b0, rd_p = 1'b0;
    logic pull_u, pull_p, al_u, al_p;
    wire  sda_line = ~(m_pull | pull_u | pull_p);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural alert model
    bit exp_u = 1'b0, exp_p = 1'b0, id_u = 1'b0, id_p = 1'b0;

    always #4 clk = ~clk;

    alert_ara_responder #(.OWN_ADDR(A_UUT)) uut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .fault(fault_u), .status_read(rd_u), .sda_pull(pull_u), .alert_pull(al_u)
    );

    alert_ara_responder #(.OWN_ADDR(A_PEER)) peer (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .fault(fault_p), .status_read(rd_p), .sda_pull(pull_p), .alert_pull(al_p)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            exp_u = 1'b0; exp_p = 1'b0; id_u = 1'b0; id_p = 1'b0;
        end else begin
            if (!exp_u && fault_u) exp_u = 1'b1;
            else if (exp_u && id_u && rd_u && !fault_u) begin exp_u = 1'b0; id_u = 1'b0; end
            if (!exp_p && fault_p) exp_p = 1'b1;
            else if (exp_p && id_p && rd_p && !fault_p) begin exp_p = 1'b0; id_p = 1'b0; end
        end
    end

    // R1 R7 R8: alert outputs against the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R1", "uut alert vs model", 32'(al_u), 32'(exp_u));
            check("R1", "peer alert vs model", 32'(al_p), 32'(exp_p));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_pull = 1'b0; scl = 1'b1; tick(Q);
        m_pull = 1'b1; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_pull = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        m_pull = 1'b0; tick(Q);
    endtask

    task automatic write_bit(input logic b);
        m_pull = ~b; tick(Q);
        scl = 1'b1; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic read_bit(output logic b);
        m_pull = 1'b0; tick(Q);
        scl = 1'b1; tick(Q / 2);
        b = sda_line; tick(Q / 2);
        scl = 1'b0; tick(Q);
    endtask

    task automatic do_ara(input logic [7:0] abyte, input string req);
        logic       b;
        logic       ack_seen;
        logic [7:0] data;
        bit         pend_u;
        bit         pend_p;
        bit         exp_ack;
        logic [7:0] exp_data;
        pend_u   = exp_u && !id_u;
        pend_p   = exp_p && !id_p;
        exp_ack  = (abyte == 8'h19) && (pend_u || pend_p);
        exp_data = 8'hFF;
        if (exp_ack) begin
            if (pend_u && (!pend_p || A_UUT < A_PEER)) exp_data = {A_UUT, 1'b0};
            else exp_data = {A_PEER, 1'b0};
        end
        bus_start();
        for (int i = 7; i >= 0; i--) write_bit(abyte[i]);
        read_bit(b);
        ack_seen = ~b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            data[i] = b;
        end
        write_bit(1'b1);
        bus_stop();
        check(req, "acknowledge", 32'(ack_seen), 32'(exp_ack));
        check(req, "returned byte", 32'(data), 32'(exp_data));
        check(req, "SDA released after stop", 32'(pull_u | pull_p), 32'd0);
        if (exp_ack) begin
            if (exp_data == {A_UUT, 1'b0}) id_u = 1'b1;
            else id_p = 1'b1;
        end
    endtask

    task automatic pulse_read(input bit on_uut);
        if (on_uut) rd_u = 1'b1; else rd_p = 1'b1;
        @(negedge clk);
        rd_u = 1'b0; rd_p = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        check("R1", "reset alert", 32'(al_u), 32'd0);
        check("R1", "reset sda", 32'(pull_u), 32'd0);

        // R3: nobody alerting -> no acknowledge
        do_ara(8'h19, "R3");

        fault_u = 1'b1; fault_p = 1'b1;
        tick(2);
        check("R1", "alert raised", 32'(al_u & al_p), 32'd1);

        // R2: own address read and ARA write are not acknowledged
        do_ara({A_UUT, 1'b1}, "R2");
        do_ara(8'h18, "R2");

        // R5: both answer, 7'h29 wins mid-byte, loser keeps alert
        do_ara(8'h19, "R5");
        check("R5", "loser alert kept", 32'(al_u), 32'd1);

        // R4: loser answers the next read with its own byte
        do_ara(8'h19, "R4");

        // R6: both identified -> no acknowledge
        do_ara(8'h19, "R6");

        // R8: status read while fault still present
        pulse_read(1'b1);
        check("R8", "read with fault present", 32'(al_u), 32'd1);
        fault_u = 1'b0;
        tick(3);
        check("R8", "fault gone without read", 32'(al_u), 32'd1);

        // R7: read after fault gone clears
        pulse_read(1'b1);
        check("R7", "uut cleared", 32'(al_u), 32'd0);
        fault_p = 1'b0;
        pulse_read(1'b0);
        check("R7", "peer cleared", 32'(al_p), 32'd0);

        // R8: raise again, read before identification does not clear
        fault_u = 1'b1;
        tick(1);
        fault_u = 1'b0;
        tick(1);
        pulse_read(1'b1);
        check("R8", "read before identification", 32'(al_u), 32'd1);

        // R6: re-raised alert is answered again
        do_ara(8'h19, "R6");
        pulse_read(1'b1);
        check("R7", "second clear", 32'(al_u), 32'd0);

        tick(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule